// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable behavioural model of a single-cycle-deselect synchronous SRAM with flow-through reads. Each word is 36 bits, split into four 9-bit byte lanes, and the depth is set by an address-width parameter. A burst is opened by one of two address strobes. The processor strobe always begins with a read and takes priority. The controller strobe may begin with either a read or a write. At the opening edge the block registers the address and the three chip enables.

After the opening edge, an advance input steps a two-bit burst counter through the rest of the four-beat burst. A mode input picks the step order, either interleaved or linear. Read data comes straight from the array addressed by the registered address, with no output register. The first beat therefore appears one cycle after the address is presented, and each later beat appears on the cycle after its advance. This gives a 2-1-1-1 pattern.

Writes go to all four lanes through a global write, or to selected lanes through a byte write enable with a mask of lanes. Output enable and a sleep input act on the output without waiting for a clock. The data bus is qualified by a valid flag instead of being tri-stated.

Top module: `sync_burst_sram`

## Requirements
- R1: The address and chip enables are captured only on a rising edge where an accepted strobe is present. An address change with no strobe leaves the accessed location unchanged.
- R2: A processor strobe (`proc_strb_ni` low) is ignored while `ce1_ni` is high. If a burst is already running, it carries on as though no strobe had been seen.
- R3: A burst opened by the processor strobe reads on its first beat even when the write enables are asserted, and memory is left unchanged.
- R4: With `order_i` = 0 (linear), beat n of the burst accesses low address bits (start + n) mod 4. The upper address bits are held.
- R5: With `order_i` = 1 (interleaved), beat n accesses low address bits start XOR n. The upper address bits are held.
- R6: The burst counter steps only on an edge with `adv_ni` low and no accepted strobe. Otherwise it holds. After the fourth beat it wraps back to the start address.
- R7: Reads are flow-through. Data for the address registered at an edge is valid right after that edge, so a burst delivers beats on four consecutive cycles. A burst of writes also stores one beat per cycle.
- R8: `gw_ni` low writes all 36 bits of `data_i` to the address in effect at that edge.
- R9: With `gw_ni` high and `bwe_ni` low, only lanes whose `lane_we_ni[k]` bit is low are written. Lane k is bits 9k+8 down to 9k. With both `gw_ni` and `bwe_ni` high, or with no lane selected, the cycle is a read.
- R10: A strobe that sees the chip enables not all active (`ce1_ni` low, `ce2_i` high, `ce3_ni` low) deselects the device. No data is output until the next accepted strobe with all enables active, whatever `adv_ni` does.
- R11: `data_vld_o` is high, and `data_o` carries the word, only while `oe_ni` is low, the device is selected and the current cycle is a read. `oe_ni` acts without a clock. Otherwise `data_o` is zero.
- R12: While `sleep_i` is high, clock edges change no state and write nothing, and the output is held invalid without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Sleep: blocks all access |
| ce1_ni | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| ce2_i | input | 1 | Chip enable 2, active high |
| ce3_ni | input | 1 | Chip enable 3, active low |
| proc_strb_ni | input | 1 | Processor address strobe, active low, priority |
| ctrl_strb_ni | input | 1 | Controller address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| order_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| gw_ni | input | 1 | Global write, active low |
| bwe_ni | input | 1 | Byte write enable, active low |
| lane_we_ni | input | 4 | Per-lane write select, active low |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| addr_i | input | ADDR_W | Word address |
| data_i | input | 36 | Write data |
| data_o | output | 36 | Read data, zero when invalid |
| data_vld_o | output | 1 | Read data valid |

## Verification
The bench first fills a window of the array with distinct single-beat global writes. It then reads it back with bursts opened from odd start addresses in both orders, so that a linear walk and an interleaved walk from the same start produce different word sequences. Bursts are run with gaps in the advance and with a fifth advance, which separates a stuck or runaway counter from a correctly wrapping one. Masked lane writes followed by a read of the merged word separate the global and per-lane enable paths. Strobes sent with bad enables, with the processor strobe gated off, or during sleep, and toggles of output enable in the middle of a read, show whether state and output respond only to accepted accesses.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int NUM_LANES = 4;
  localparam int LANE_W    = 9;
  localparam int WORD_W    = NUM_LANES * LANE_W;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_ord_e;

  typedef struct packed {
    logic                 start;     // accepted strobe this edge
    logic                 proc_acc;  // processor strobe accepted
    logic                 ce_ok;     // all chip enables active
    logic [NUM_LANES-1:0] lane_we;   // lanes requested for write
  } cmd_t;

  function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                          input logic [1:0] beat,
                                          input burst_ord_e ord);
    logic [1:0] r;
    if (ord == ORD_INTERLEAVE) r = base ^ beat;
    else                       r = base + beat;
    return r;
  endfunction
endpackage

// File: rtl/sbs_cmd_decode.sv
module sbs_cmd_decode
  import sbs_pkg::*;
(
  input  logic                 ce1_ni,
  input  logic                 ce2_i,
  input  logic                 ce3_ni,
  input  logic                 proc_strb_ni,
  input  logic                 ctrl_strb_ni,
  input  logic                 gw_ni,
  input  logic                 bwe_ni,
  input  logic [NUM_LANES-1:0] lane_we_ni,
  output cmd_t                 cmd_o
);
  logic proc_acc;
  logic [NUM_LANES-1:0] mask;

  assign proc_acc = !proc_strb_ni && !ce1_ni;

  always_comb begin
    if (!gw_ni)       mask = '1;
    else if (!bwe_ni) mask = ~lane_we_ni;
    else              mask = '0;
  end

  assign cmd_o.start    = proc_acc || !ctrl_strb_ni;
  assign cmd_o.proc_acc = proc_acc;
  assign cmd_o.ce_ok    = !ce1_ni && ce2_i && !ce3_ni;
  assign cmd_o.lane_we  = mask;
endmodule

// File: rtl/sbs_burst_ctr.sv
module sbs_burst_ctr
  import sbs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       adv_i,
  input  logic [1:0] base_i,
  input  logic       order_i,
  output logic [1:0] lo_o,
  output logic [1:0] lo_next_o,
  output logic [1:0] beat_o,
  output logic       order_o
);
  logic [1:0] base_q, beat_q, beat_inc;
  burst_ord_e ord_q;

  assign beat_inc = beat_q + 2'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      beat_q <= '0;
      ord_q  <= ORD_LINEAR;
    end else if (load_i) begin
      base_q <= base_i;
      beat_q <= '0;
      ord_q  <= burst_ord_e'(order_i);
    end else if (adv_i) begin
      beat_q <= beat_inc;
    end
  end

  assign lo_o      = burst_lo(base_q, beat_q, ord_q);
  assign lo_next_o = burst_lo(base_q, beat_inc, ord_q);
  assign beat_o    = beat_q;
  assign order_o   = ord_q;
endmodule

// File: rtl/sbs_mem_array.sv
module sbs_mem_array
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                 clk_i,
  input  logic [NUM_LANES-1:0] we_i,
  input  logic [ADDR_W-1:0]    waddr_i,
  input  logic [WORD_W-1:0]    wdata_i,
  input  logic [ADDR_W-1:0]    raddr_i,
  output logic [WORD_W-1:0]    rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i[l]) mem[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sleep_i,
  input  logic                 ce1_ni,
  input  logic                 ce2_i,
  input  logic                 ce3_ni,
  input  logic                 proc_strb_ni,
  input  logic                 ctrl_strb_ni,
  input  logic                 adv_ni,
  input  logic                 order_i,
  input  logic                 gw_ni,
  input  logic                 bwe_ni,
  input  logic [NUM_LANES-1:0] lane_we_ni,
  input  logic                 oe_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [WORD_W-1:0]    data_i,
  output logic [WORD_W-1:0]    data_o,
  output logic                 data_vld_o
);
  localparam int HI_W = ADDR_W - 2;

  cmd_t cmd;
  logic go, load, desel, cont, adv_en;
  logic sel_q, wr_q;
  logic [HI_W-1:0] hi_q;
  logic [1:0] lo_cur, lo_nxt, beat_q;
  logic ord_q;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [NUM_LANES-1:0] we;
  logic [WORD_W-1:0] rdata;
  logic drive;

  sbs_cmd_decode u_dec (
    .ce1_ni      (ce1_ni),
    .ce2_i       (ce2_i),
    .ce3_ni      (ce3_ni),
    .proc_strb_ni(proc_strb_ni),
    .ctrl_strb_ni(ctrl_strb_ni),
    .gw_ni       (gw_ni),
    .bwe_ni      (bwe_ni),
    .lane_we_ni  (lane_we_ni),
    .cmd_o       (cmd)
  );

  assign go     = !sleep_i;
  assign load   = go && cmd.start && cmd.ce_ok;
  assign desel  = go && cmd.start && !cmd.ce_ok;
  assign cont   = go && !cmd.start && sel_q;
  assign adv_en = cont && !adv_ni;

  sbs_burst_ctr u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .adv_i    (adv_en),
    .base_i   (addr_i[1:0]),
    .order_i  (order_i),
    .lo_o     (lo_cur),
    .lo_next_o(lo_nxt),
    .beat_o   (beat_q),
    .order_o  (ord_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= 1'b0;
      wr_q  <= 1'b0;
      hi_q  <= '0;
    end else if (load) begin
      sel_q <= 1'b1;
      wr_q  <= !cmd.proc_acc && (|cmd.lane_we);
      hi_q  <= addr_i[ADDR_W-1:2];
    end else if (desel) begin
      sel_q <= 1'b0;
      wr_q  <= 1'b0;
    end else if (cont) begin
      wr_q  <= |cmd.lane_we;
    end
  end

  // first beat of a processor-strobe burst never writes
  assign we    = ((load && !cmd.proc_acc) || cont) ? cmd.lane_we : '0;
  assign waddr = load ? addr_i : {hi_q, (adv_en ? lo_nxt : lo_cur)};
  assign raddr = {hi_q, lo_cur};

  sbs_mem_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i  (clk_i),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(data_i),
    .raddr_i(raddr),
    .rdata_o(rdata)
  );

  assign drive      = sel_q && !wr_q && !oe_ni && !sleep_i;
  assign data_vld_o = drive;
  assign data_o     = drive ? rdata : '0;
endmodule

// File: rtl/sbs_sram_chk.sv
module sbs_sram_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sleep_i,
  input logic       oe_ni,
  input logic       adv_ni,
  input logic       data_vld_o,
  input logic       start,
  input logic       proc_acc,
  input logic       ce_ok,
  input logic       sel_q,
  input logic [1:0] beat_q,
  input logic [1:0] lo_cur,
  input logic       ord_q
);
  logic [1:0] lo_inc;
  assign lo_inc = lo_cur + 2'd1;

  assert_oe_blocks_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !data_vld_o);

  assert_sleep_blocks_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !data_vld_o);

  assert_sleep_holds_ctr_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> $stable(beat_q));

  assert_deselect_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && start && !ce_ok) |=> !data_vld_o);

  assert_proc_first_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && proc_acc && ce_ok) |=> (oe_ni || sleep_i || data_vld_o));

  assert_ctr_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && !start && adv_ni) |=> $stable(beat_q));

  assert_linear_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_i && !start && sel_q && !adv_ni && !ord_q) |=> (lo_cur == $past(lo_inc)));
endmodule

bind sync_burst_sram sbs_sram_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sleep_i   (sleep_i),
  .oe_ni     (oe_ni),
  .adv_ni    (adv_ni),
  .data_vld_o(data_vld_o),
  .start     (cmd.start),
  .proc_acc  (cmd.proc_acc),
  .ce_ok     (cmd.ce_ok),
  .sel_q     (sel_q),
  .beat_q    (beat_q),
  .lo_cur    (lo_cur),
  .ord_q     (ord_q)
);

// File: tb/sync_burst_sram_tb.sv
module sync_burst_sram_tb;
  localparam int AW = 6;
  localparam int WW = 36;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic sleep_i, ce1_ni, ce2_i, ce3_ni, proc_strb_ni, ctrl_strb_ni, adv_ni;
  logic order_i, gw_ni, bwe_ni, oe_ni;
  logic [3:0] lane_we_ni;
  logic [AW-1:0] addr_i;
  logic [WW-1:0] data_i, data_o;
  logic data_vld_o;

  always #4 clk_i = ~clk_i;

  sync_burst_sram #(.ADDR_W(AW)) u_dut (.*);

  int n_cmp = 0;
  int n_bad = 0;
  logic          q_vld [$];
  logic [WW-1:0] q_dat [$];
  string         q_req [$];

  // bench reference state
  logic [WW-1:0] mdl [64];
  logic       m_sel = 0, m_wr = 0, m_ord = 0;
  logic [3:0] m_hi = 0;
  logic [1:0] m_base = 0, m_beat = 0;

  function automatic logic [WW-1:0] pat(input int k);
    return 36'(k) * 36'h0_0123_4567 ^ 36'h9_5A5A_A5A5;
  endfunction

  task automatic idle();
    sleep_i = 0; ce1_ni = 0; ce2_i = 1; ce3_ni = 0;
    proc_strb_ni = 1; ctrl_strb_ni = 1; adv_ni = 1; order_i = 0;
    gw_ni = 1; bwe_ni = 1; lane_we_ni = 4'hF; oe_ni = 0;
    addr_i = '0; data_i = '0;
  endtask

  task automatic step(input string req);
    logic pacc, st, ceok, we;
    logic [3:0] m;
    logic [5:0] cur;
    logic ev;
    m = !gw_ni ? 4'hF : (!bwe_ni ? ~lane_we_ni : 4'h0);
    we = 0;
    if (!sleep_i) begin
      pacc = !proc_strb_ni && !ce1_ni;
      st   = pacc || !ctrl_strb_ni;
      ceok = !ce1_ni && ce2_i && !ce3_ni;
      if (st) begin
        if (ceok) begin
          m_sel = 1; m_hi = addr_i[5:2]; m_base = addr_i[1:0]; m_beat = 0;
          m_ord = order_i; m_wr = !pacc && (m != 0); we = m_wr;
        end else begin
          m_sel = 0; m_wr = 0;
        end
      end else if (m_sel) begin
        if (!adv_ni) m_beat = m_beat + 2'd1;
        m_wr = (m != 0); we = m_wr;
      end
    end
    cur = {m_hi, (m_ord ? (m_base ^ m_beat) : 2'(m_base + m_beat))};
    if (we)
      for (int l = 0; l < 4; l++)
        if (m[l]) mdl[cur][l*9 +: 9] = data_i[l*9 +: 9];
    ev = !sleep_i && m_sel && !m_wr && !oe_ni;
    q_vld.push_back(ev);
    q_dat.push_back(ev ? mdl[cur] : '0);
    q_req.push_back(req);
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // monitor
  always @(posedge clk_i) begin
    #2;
    if (q_vld.size() > 0) begin
      logic ev;
      logic [WW-1:0] ed;
      string r;
      ev = q_vld.pop_front(); ed = q_dat.pop_front(); r = q_req.pop_front();
      n_cmp++;
      if (data_vld_o !== ev || data_o !== ed) begin
        n_bad++;
        $display("FAIL %s: vld=%0b data=%h expected vld=%0b data=%h", r, data_vld_o, data_o, ev, ed);
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle();
    rst_ni = 0;
    repeat (3) @(posedge clk_i);
    #2;
    n_cmp++;
    if (data_vld_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 reset: vld=%0b expected 0", data_vld_o);
    end
    @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // preload with single-beat global writes (R8)
    for (int k = 0; k < 32; k++) begin
      idle(); ctrl_strb_ni = 0; gw_ni = 0; addr_i = AW'(k); data_i = pat(k);
      step("R8");
    end

    // processor burst, linear, write enables ignored (R3, R4, R6)
    idle(); proc_strb_ni = 0; gw_ni = 0; data_i = '1; addr_i = 6'd5;
    step("R3");
    idle(); adv_ni = 0;
    step("R4"); step("R4"); step("R4");
    step("R6");                              // wrap to start
    adv_ni = 1; step("R6"); step("R6");      // hold
    addr_i = 6'd30; step("R1");              // address change alone ignored
    // gated processor strobe ignored, burst advances (R2)
    proc_strb_ni = 0; ce1_ni = 1; adv_ni = 0; step("R2");
    idle(); step("R2");

    // interleaved from odd start (R5)
    idle(); ctrl_strb_ni = 0; order_i = 1; addr_i = 6'd9;
    step("R5");
    idle(); adv_ni = 0; order_i = 0;         // order latched at start
    step("R5"); step("R5"); step("R5");

    // back-to-back linear read burst (R7)
    idle(); ctrl_strb_ni = 0; addr_i = 6'd13;
    step("R7");
    idle(); adv_ni = 0;
    step("R7"); step("R7"); step("R7");

    // burst write then read back (R7, R8)
    idle(); ctrl_strb_ni = 0; gw_ni = 0; addr_i = 6'd18; data_i = 36'h1_1111_1111;
    step("R7");
    idle(); gw_ni = 0; adv_ni = 0; data_i = 36'h2_2222_2222; step("R7");
    data_i = 36'h3_3333_3333; step("R7");
    data_i = 36'h4_4444_4444; step("R7");
    idle(); ctrl_strb_ni = 0; addr_i = 6'd18; step("R8");
    idle(); adv_ni = 0; step("R8"); step("R8"); step("R8");

    // lane writes: lanes 0 and 2 selected (R9)
    idle(); ctrl_strb_ni = 0; bwe_ni = 0; lane_we_ni = 4'b1010; addr_i = 6'd3;
    data_i = 36'hF_0F0F_0F0F;
    step("R9");
    idle(); ctrl_strb_ni = 0; lane_we_ni = 4'h0; addr_i = 6'd3; step("R9");
    idle(); bwe_ni = 0; lane_we_ni = 4'hF; data_i = '1; step("R9"); // no lane -> read

    // deselect (R10)
    idle(); ctrl_strb_ni = 0; ce2_i = 0; addr_i = 6'd4; step("R10");
    idle(); adv_ni = 0; step("R10"); step("R10");
    idle(); ctrl_strb_ni = 0; ce3_ni = 1; addr_i = 6'd4; step("R10");
    idle(); ctrl_strb_ni = 0; addr_i = 6'd4; step("R10");

    // output enable (R11)
    idle(); oe_ni = 1; step("R11");
    oe_ni = 0; step("R11");

    // sleep (R12)
    idle(); sleep_i = 1; ctrl_strb_ni = 0; gw_ni = 0; addr_i = 6'd2; data_i = '0;
    step("R12");
    idle(); sleep_i = 1; adv_ni = 0; step("R12");
    idle(); step("R12");                     // still on address 4, counter unmoved
    idle(); ctrl_strb_ni = 0; addr_i = 6'd2; step("R12");

    idle();
    repeat (3) @(posedge clk_i);
    #3;
    if (q_vld.size() != 0) begin
      n_bad++;
      $display("FAIL R7: %0d results missing, expected 0", q_vld.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule